// File: doc/BRIEF.md
# Successive-Approximation ADC Serial Port Model

This block models the digital side of a 12-bit successive-approximation converter that sits on a four-wire serial bus, with the bus master's serial clock driving the conversion. While chip select is low, the block watches the data input. The first 1 it samples on a rising serial-clock edge opens an 8-bit control byte, and that byte picks the input channel, the input configuration and the output coding. One serial-clock period after the byte, a strobe output pulses high. On the following twelve falling edges the block then streams out its bit decisions, most significant bit first. The data line stays low for the rest of the 24-clock frame.

The analog comparator is replaced by an ideal digital stand-in. For each channel the block takes a 12-bit offset-binary code. It holds the selected code at the end of the control byte, and then builds the result one bit at a time by comparing a trial value against that held code. The data and strobe outputs are each paired with a drive enable. Both enables fall when chip select is high, which stands for high impedance. The serial inputs are retimed into the block clock domain through a configurable synchronizer, and edges are detected on the retimed copies.

Top module: `sar_adc_serial_port`

## Requirements
- R1: While chip select is high, `dout_oe` and `strb_oe` are 0. After chip select falls, both enables are 1, and `strb` and `dout` are driven 0.
- R2: Zeros sampled on rising serial-clock edges before the first 1 are ignored. That first 1 is bit 7 of the control byte, and the bits arrive MSB first. Bits 6:4 give the channel number. Bit 3 = 1 selects unipolar and 0 selects bipolar. Bit 2 = 1 selects single-ended and 0 selects differential. Bits 1:0 give the clock/power field.
- R3: On the falling edge after the eighth control bit, `strb` goes high. It stays high for exactly one serial-clock period, and `dout` is 0 during that period.
- R4: On each of the next 12 falling edges, `dout` presents one decision, from B11 down to B0.
- R5: In unipolar mode, the 12 decisions equal the selected channel's code as straight binary. All-zero and all-one codes are included.
- R6: In bipolar mode, the 12 decisions are the selected code with its MSB inverted, which gives two's complement.
- R7: In single-ended mode, the channel field picks the code slice `ch_codes[ch*12 +: 12]`.
- R8: After B0, `dout` is 0 for the rest of the frame. A new start bit after the frame begins another conversion without toggling chip select.
- R9: If bits 1:0 of the control byte are not 11, there is no strobe pulse and `dout` stays 0 for the frame.
- R10: If chip select rises during a frame, the conversion is abandoned and both enables drop. The next frame after chip select falls converts normally.
- R11: The selected code is held when the eighth control bit arrives. Changes to `ch_codes` after that point do not alter the result.
- R12: In differential mode, channels form pairs (0,1), (2,3) and so on. The conversion uses the code of the even member of the pair named by the channel field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data, sampled on serial-clock rising edges |
| ch_codes | input | NCH*RES (96) | Stand-in comparator codes, one offset-binary slice per channel |
| dout | output | 1 | Serial result data, updated on serial-clock falling edges |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |
| strb | output | 1 | Conversion strobe |
| strb_oe | output | 1 | Drive enable for `strb`; 0 means high impedance |

## Verification
The bench covers the following corner cases, each with the failure it would show:
- Strobe timing. An off-by-one in the control-bit count moves the strobe or the whole code by one slot, which shows up as a misplaced pulse or a shifted code.
- Extreme codes. All-zero and all-one codes check the comparison. A strict-versus-inclusive compare error loses the LSB at full scale.
- Bipolar inversion. Mistakes here appear as a wrong MSB.
- Zero padding and channel slicing. Missing padding or a wrong slice yields stray ones or the wrong channel's code.
- Abort, non-11 clock field and late sample changes. An abort that leaves stale state, a conversion started by a non-11 field, or a comparator that reads the live input instead of the held code each produce a strobe or code that differs from the expected one.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

   localparam int CTRL_LEN = 8;
   localparam int POS_START = 7;
   localparam int POS_CH_HI = 6;
   localparam int POS_CH_LO = 4;
   localparam int POS_UNI = 3;
   localparam int POS_SGL = 2;
   localparam logic [1:0] CLK_EXT_CODE = 2'b11;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ARM,
      ST_CONV
   } port_state_e;

   typedef struct packed {
      logic       start;
      logic [2:0] ch;
      logic       unipolar;
      logic       single;
      logic [1:0] clkmode;
   } ctrl_word_t;

   function automatic ctrl_word_t unpack_ctrl(input logic [CTRL_LEN-1:0] b);
      ctrl_word_t w;
      w.start    = b[POS_START];
      w.ch       = b[POS_CH_HI:POS_CH_LO];
      w.unipolar = b[POS_UNI];
      w.single   = b[POS_SGL];
      w.clkmode  = b[1:0];
      return w;
   endfunction

endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = raw_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= raw_i;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign sync_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sar_sclk_edges.sv
module sar_sclk_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sclk_s;
   end

   assign rise_o = sclk_s & ~prev_q;
   assign fall_o = ~sclk_s & prev_q;

endmodule

// File: rtl/sar_ctrl_rx.sv
module sar_ctrl_rx
   import sar_port_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                shift_i,
   input  logic                din_i,
   output logic                done_o,
   output logic [CTRL_LEN-1:0] byte_o
);

   localparam int CW = $clog2(CTRL_LEN);

   logic [CTRL_LEN-2:0] shreg_q;
   logic [CW-1:0]       cnt_q;

   assign done_o = shift_i && (cnt_q == CW'(CTRL_LEN - 1));
   assign byte_o = {shreg_q, din_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (shift_i) begin
         shreg_q <= {shreg_q[CTRL_LEN-3:0], din_i};
         cnt_q   <= done_o ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
   parameter int RES = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [RES-1:0]         sample_i,
   input  logic                   step_i,
   output logic                   decide_o,
   output logic                   msb_o,
   output logic                   last_o
);

   localparam int IW = $clog2(RES);

   logic [RES-1:0] held_q;
   logic [RES-1:0] res_q;
   logic [IW-1:0]  idx_q;
   logic [RES-1:0] trial;

   assign trial    = res_q | (RES'(1) << idx_q);
   assign decide_o = (held_q >= trial);
   assign msb_o    = (idx_q == IW'(RES - 1));
   assign last_o   = (idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         res_q  <= '0;
         idx_q  <= IW'(RES - 1);
      end else if (load_i) begin
         held_q <= sample_i;
         res_q  <= '0;
         idx_q  <= IW'(RES - 1);
      end else if (step_i) begin
         if (decide_o) res_q <= trial;
         if (!last_o)  idx_q <= idx_q - 1'b1;
      end
   end

   // the partial result never passes the held sample (R5)
   assert_partial_le_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_q <= held_q);

endmodule

// File: rtl/sar_adc_serial_port.sv
module sar_adc_serial_port
   import sar_port_pkg::*;
#(
   parameter int RES = 12,
   parameter int NCH = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               din,
   input  logic [NCH*RES-1:0] ch_codes,
   output logic               dout,
   output logic               dout_oe,
   output logic               strb,
   output logic               strb_oe
);

   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (RES < 2) begin : g_bad_res
         $error("RES must be at least 2");
      end
      if (NCH < 2 || NCH > 8 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
         $error("NCH must be 2, 4 or 8");
      end
   endgenerate

   logic [2:0] raw_bus, sync_bus;
   logic       sclk_s, cs_s, din_s;
   logic       rise, fall;
   logic       byte_done, shift_en;
   logic [CTRL_LEN-1:0] ctrl_byte;
   ctrl_word_t ctrl;
   logic [CHW-1:0] ch_pick;
   logic [RES-1:0] picked_code;
   logic       start_conv;
   logic       decide, at_msb, at_last;
   port_state_e state_q;
   logic       bipolar_q;

   assign raw_bus = {cs_n, sclk, din};

   sar_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_bus), .sync_o(sync_bus)
   );
   assign cs_s   = sync_bus[2];
   assign sclk_s = sync_bus[1];
   assign din_s  = sync_bus[0];

   sar_sclk_edges u_edges (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .rise_o(rise), .fall_o(fall)
   );

   assign shift_en = rise && !cs_s &&
                     ((state_q == ST_IDLE && din_s) || state_q == ST_CTRL);

   sar_ctrl_rx u_rx (
      .clk(clk), .rst_n(rst_n), .clear_i(cs_s), .shift_i(shift_en),
      .din_i(din_s), .done_o(byte_done), .byte_o(ctrl_byte)
   );

   assign ctrl    = unpack_ctrl(ctrl_byte);
   assign ch_pick = ctrl.single ? ctrl.ch[CHW-1:0] : (ctrl.ch[CHW-1:0] & ~CHW'(1));
   assign picked_code = ch_codes[ch_pick*RES +: RES];
   assign start_conv  = byte_done && ctrl.start && (ctrl.clkmode == CLK_EXT_CODE);

   sar_engine #(.RES(RES)) u_sar (
      .clk(clk), .rst_n(rst_n), .load_i(start_conv), .sample_i(picked_code),
      .step_i(fall && state_q == ST_CONV && !cs_s),
      .decide_o(decide), .msb_o(at_msb), .last_o(at_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         dout      <= 1'b0;
         strb      <= 1'b0;
         bipolar_q <= 1'b0;
      end else if (cs_s) begin
         state_q   <= ST_IDLE;
         dout      <= 1'b0;
         strb      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (shift_en) state_q <= ST_CTRL;
            ST_CTRL: if (byte_done) begin
               if (start_conv) begin
                  state_q   <= ST_ARM;
                  bipolar_q <= ~ctrl.unipolar;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_ARM: if (fall) begin
               strb    <= 1'b1;
               state_q <= ST_CONV;
            end
            ST_CONV: if (fall) begin
               strb <= 1'b0;
               dout <= decide ^ (bipolar_q & at_msb);
               if (at_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (fall && state_q != ST_CONV) dout <= 1'b0;
      end
   end

   assign dout_oe = ~cs_s;
   assign strb_oe = ~cs_s;

   // strobe lasts a single serial-clock period (R3)
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && fall) |=> !strb);

   // strobe only accompanies an accepted conversion (R9)
   assert_strobe_in_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (state_q == ST_CONV));

   // outputs start low once chip select is asserted (R1)
   assert_low_after_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_s) |-> (!strb && !dout));

   // data changes only on a serial-clock falling edge (R4)
   assert_dout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && $past(!cs_s) && !$past(fall)) |-> $stable(dout));

endmodule

// File: tb/tb_sar_adc_serial_port.sv
module tb_sar_adc_serial_port;

   localparam int RES = 12;
   localparam int NCH = 8;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic din = 1'b0;
   logic [NCH*RES-1:0] ch_codes = '0;
   logic dout, dout_oe, strb, strb_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic cap_d [0:63];
   logic cap_s [0:63];
   int   pos;

   always #5 clk = ~clk;

   sar_adc_serial_port #(.RES(RES), .NCH(NCH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
      .ch_codes(ch_codes), .dout(dout), .dout_oe(dout_oe),
      .strb(strb), .strb_oe(strb_oe)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(input int ch, input bit uni, input bit sgl,
                                      input logic [1:0] pd);
      return {1'b1, 3'(ch), uni, sgl, pd};
   endfunction

   task automatic set_code(input int ch, input logic [11:0] v);
      ch_codes[ch*RES +: RES] = v;
   endtask

   task automatic xfer(input logic b);
      @(negedge clk);
      din = b;
      pos++;
      cap_d[pos] = dout;
      cap_s[pos] = strb;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic run_frame(input logic [7:0] c, input int lead,
                            input bit chg, input int chg_ch, input logic [11:0] chg_v);
      pos = 0;
      for (int i = 0; i < lead; i++) xfer(1'b0);
      for (int i = 7; i >= 0; i--) xfer(c[i]);
      if (chg) set_code(chg_ch, chg_v);
      for (int i = 0; i < 16; i++) xfer(1'b0);
   endtask

   task automatic check_frame(input logic [11:0] exp, input int lead, input string rq);
      logic [11:0] got;
      int nstrb, spos, stray;
      nstrb = 0; spos = -1; stray = 0;
      for (int j = 0; j < 12; j++) got[11-j] = cap_d[lead+10+j];
      for (int k = 1; k <= pos; k++) begin
         if (cap_s[k]) begin nstrb++; spos = k; end
         if (cap_d[k] && (k < lead+10 || k > lead+21)) stray++;
      end
      chk(got == exp, {rq, " code"}, got, exp);
      chk(nstrb == 1 && spos == lead+9, "R3 strobe slot", spos, lead+9);
      chk(stray == 0, "R8 zero fill", stray, 0);
   endtask

   task automatic select_low();
      @(negedge clk); cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic select_high();
      @(negedge clk); cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(dout_oe == 0 && strb_oe == 0, "R1 released under reset/CS high",
          {dout_oe, strb_oe}, 0);
      select_low();
      chk(dout_oe && strb_oe && !strb && !dout, "R1 driven low after CS falls",
          {dout_oe, strb_oe, strb, dout}, 4'b1100);
   endtask

   task automatic t_unipolar();
      set_code(3, 12'hA5C);
      run_frame(ctl(3, 1, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'hA5C, 0, "R4 R5 R7 unipolar ch3");
   endtask

   task automatic t_bipolar();
      set_code(5, 12'h123);
      run_frame(ctl(5, 0, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'h923, 0, "R6 bipolar ch5");
      set_code(6, 12'hC00);
      run_frame(ctl(6, 0, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'h400, 0, "R6 bipolar ch6");
   endtask

   task automatic t_lead_and_extremes();
      set_code(1, 12'hFFF);
      run_frame(ctl(1, 1, 1, 2'b11), 5, 0, 0, 0);
      check_frame(12'hFFF, 5, "R2 R5 leading zeros full scale");
      set_code(0, 12'h000);
      run_frame(ctl(0, 1, 1, 2'b11), 2, 0, 0, 0);
      check_frame(12'h000, 2, "R5 zero code");
   endtask

   task automatic t_diff();
      set_code(2, 12'h3C7);
      set_code(3, 12'h811);
      run_frame(ctl(3, 1, 0, 2'b11), 0, 0, 0, 0);
      check_frame(12'h3C7, 0, "R12 differential pair");
   endtask

   task automatic t_no_conv(input logic [1:0] pd);
      int ones;
      set_code(4, 12'hFFF);
      run_frame(ctl(4, 1, 1, pd), 0, 0, 0, 0);
      ones = 0;
      for (int k = 1; k <= pos; k++) ones += int'(cap_d[k]) + int'(cap_s[k]);
      chk(ones == 0, "R9 no conversion for clock field", ones, 0);
   endtask

   task automatic t_back_to_back();
      set_code(7, 12'h5A5);
      run_frame(ctl(7, 1, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'h5A5, 0, "R8 first frame");
      set_code(6, 12'h0F1);
      run_frame(ctl(6, 1, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'h0F1, 0, "R8 second frame");
   endtask

   task automatic t_abort();
      logic [7:0] c;
      c = ctl(2, 1, 1, 2'b11);
      set_code(2, 12'hFFF);
      pos = 0;
      for (int i = 7; i >= 0; i--) xfer(c[i]);
      for (int i = 0; i < 5; i++) xfer(1'b0);
      select_high();
      chk(dout_oe == 0 && strb_oe == 0, "R10 released on abort", {dout_oe, strb_oe}, 0);
      select_low();
      chk(!strb && !dout, "R10 low after reselect", {strb, dout}, 0);
      set_code(2, 12'h6B2);
      run_frame(ctl(2, 1, 1, 2'b11), 0, 0, 0, 0);
      check_frame(12'h6B2, 0, "R10 frame after abort");
   endtask

   task automatic t_hold();
      set_code(1, 12'h7E3);
      run_frame(ctl(1, 1, 1, 2'b11), 0, 1, 1, 12'h01C);
      check_frame(12'h7E3, 0, "R11 held sample");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_unipolar();
      t_bipolar();
      t_lead_and_extremes();
      t_diff();
      t_no_conv(2'b10);
      t_no_conv(2'b00);
      t_back_to_back();
      t_abort();
      t_hold();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule